// File: doc/BRIEF.md
# Twin-Aspect Synchronous Block Memory

This block is a 4096-bit storage array with two fully synchronous ports. Each port sees the same bits through its own data width, chosen by parameter from 1, 2, 4, 8 or 16 bits. The port's depth is 4096 divided by that width. Word k of a port that is W bits wide is the run of bits starting at bit k*W of the linear array. A value written as one byte on one port can therefore be read back as bit pairs, nibbles or single bits on the other port.

Every access needs a clock edge. Enable, write enable, address and write data are captured at the rising edge, and read data comes from an output register. No combinational path runs from address to read data. The two ports share the clock edge, so collisions between them are defined cycle by cycle. Each read register shows the array contents as they stand after that edge's writes. Where both ports write the same bits in one cycle, port A's data is kept.

Top module: `twin_view_ram`

## Requirements
- R1: While rst_n is low at a rising edge, both read outputs become 0 and no write reaches the array, even with enable and write enable high.
- R2: Word k of a W-bit port occupies linear array bits [k*W +: W], with bit 0 of the word at the lowest array bit. Data written through one port is read back through the other port at that port's width.
- R3: Read data changes only at a rising edge. A new address with enable high appears on the read output after the next rising edge, and never before it.
- R4: A port that writes with enable high shows its own new write data on its read output after that edge (write-first).
- R5: When both ports write overlapping bits at the same edge, those bits take port A's data. Bits of port B's word outside the overlap take port B's data. Both read outputs show the merged result.
- R6: A read on one port of bits that the other port writes at the same edge returns the newly written bits.
- R7: With a port's enable low, its read output holds its value and its write enable is ignored.
- R8: An enabled access with write enable low changes no stored bit.
- R9: The two ports operate at the same time. Writes at the same edge to non-overlapping bits both take effect.
- R10: Each port width parameter must be one of 1, 2, 4, 8 or 16, and that port's address width is log2(4096/width).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock shared by both ports |
| rst_n | input | 1 | Synchronous active-low reset of both read registers |
| a_en | input | 1 | Port A access enable |
| a_we | input | 1 | Port A write enable, qualified by a_en |
| a_addr | input | A_AW | Port A word address |
| a_wdata | input | A_WIDTH | Port A write data |
| a_rdata | output | A_WIDTH | Port A registered read data |
| b_en | input | 1 | Port B access enable |
| b_we | input | 1 | Port B write enable, qualified by b_en |
| b_addr | input | B_AW | Port B word address |
| b_wdata | input | B_WIDTH | Port B write data |
| b_rdata | output | B_WIDTH | Port B registered read data |

## Verification
A wrong lane shift or row index corrupts the word of the port concerned. The error is visible on the opposite port's next read of those bits, one edge after that read is issued. A lost collision rule or a broken write-first merge shows on the read output exactly one edge after the colliding write. A register that fails to hold shows up as a changed value on the first cycle after the enable drops. Random traffic with forced overlaps is compared each cycle against a bit-level model, so any stored corruption appears at the ports within the cycles it takes to read the affected word again.

// File: rtl/twin_view_pkg.sv
// Shared constants and helpers for the twin-aspect memory.
// Assumes the array is organised as rows of ROW_BITS bits, ROW_BITS being
// the widest port width allowed.
package twin_view_pkg;

    localparam int unsigned ROW_BITS = 16;

    // True when a width is one of the legal port widths.
    function automatic bit legal_width(input int unsigned w);
        return (w == 1) || (w == 2) || (w == 4) || (w == 8) || (w == 16);
    endfunction

    // Merge new data into a row under a bit mask.
    function automatic logic [ROW_BITS-1:0] merge_row(
        input logic [ROW_BITS-1:0] old_row,
        input logic [ROW_BITS-1:0] mask,
        input logic [ROW_BITS-1:0] data
    );
        return (old_row & ~mask) | (data & mask);
    endfunction

endpackage

// File: rtl/tv_lane_decode.sv
// Splits one port's word address into a row index and a lane shift.
// It also builds the row-aligned write mask and write data.
// Assumes WIDTH divides ROWW and both are powers of two.
module tv_lane_decode #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned TOTAL = 4096,
    parameter int unsigned ROWW  = 16,
    parameter int unsigned AW    = $clog2(TOTAL / WIDTH),
    parameter int unsigned RAW   = $clog2(TOTAL / ROWW),
    parameter int unsigned SHW   = $clog2(ROWW)
) (
    input  logic [AW-1:0]    addr,
    input  logic [WIDTH-1:0] wdata,
    output logic [RAW-1:0]   row,
    output logic [SHW-1:0]   shift,
    output logic [ROWW-1:0]  mask,
    output logic [ROWW-1:0]  wrow
);
    localparam int unsigned LANES = ROWW / WIDTH;
    localparam int unsigned WB    = $clog2(WIDTH);

    generate
        if (LANES == 1) begin : g_full_row
            // Port as wide as a row: address is the row, no shift.
            assign row   = addr;
            assign shift = '0;
        end else begin : g_lanes
            localparam int unsigned LB = $clog2(LANES);
            // Upper address bits pick the row, lower bits pick the lane.
            assign row   = addr[AW-1:LB];
            assign shift = SHW'(addr[LB-1:0]) << WB;
        end
    endgenerate

    // Place the word's ones and its data at the lane position.
    always_comb begin
        mask = ROWW'({WIDTH{1'b1}}) << shift;
        wrow = ROWW'(wdata) << shift;
    end

endmodule

// File: rtl/tv_array.sv
// Row-organised storage shared by both ports.
// Outputs, for each port's row, the row value after this edge's writes.
// Port A's bits take priority over port B's where the two overlap.
// Assumes the write strobes are already qualified by enable and reset.
module tv_array
    import twin_view_pkg::*;
#(
    parameter int unsigned ROWS = 256,
    parameter int unsigned RAW  = $clog2(ROWS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_a,
    input  logic [RAW-1:0]      row_a,
    input  logic [ROW_BITS-1:0] mask_a,
    input  logic [ROW_BITS-1:0] data_a,
    input  logic                wr_b,
    input  logic [RAW-1:0]      row_b,
    input  logic [ROW_BITS-1:0] mask_b,
    input  logic [ROW_BITS-1:0] data_b,
    output logic [ROW_BITS-1:0] next_a,
    output logic [ROW_BITS-1:0] next_b
);
    logic [ROW_BITS-1:0] mem [ROWS];

    // Row contents after the edge as seen by each port: B applied first, A on top.
    always_comb begin
        next_a = mem[row_a];
        if (wr_b && (row_b == row_a)) next_a = merge_row(next_a, mask_b, data_b);
        if (wr_a) next_a = merge_row(next_a, mask_a, data_a);
        next_b = mem[row_b];
        if (wr_b) next_b = merge_row(next_b, mask_b, data_b);
        if (wr_a && (row_a == row_b)) next_b = merge_row(next_b, mask_a, data_a);
    end

    // Commit merged rows; identical values when both hit one row.
    always_ff @(posedge clk) begin
        if (wr_b) mem[row_b] <= next_b;
        if (wr_a) mem[row_a] <= next_a;
    end

    // R5: overlapping bits hold port A's data after a double write.
    a_r5_a_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_a && wr_b && (row_a == row_b)) |=>
        ((mem[$past(row_a)] & $past(mask_a)) == ($past(data_a) & $past(mask_a))));

    // R8: with no write strobe, port A's row keeps its contents.
    a_r8_no_write_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_a && !wr_b) |=> (mem[$past(row_a)] == $past(mem[row_a])));

endmodule

// File: rtl/tv_read_reg.sv
// Registered read data of one port: picks the port's lane out of the
// post-write row when the port is enabled, else holds. Clears on reset.
module tv_read_reg #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned ROWW  = 16,
    parameter int unsigned SHW   = $clog2(ROWW)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [ROWW-1:0]  row_val,
    input  logic [SHW-1:0]   shift,
    output logic [WIDTH-1:0] q
);
    // Capture the selected lane on an enabled edge.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (en) q <= WIDTH'(row_val >> shift);
    end

    // R1: reset clears the output register.
    a_r1_clear: assert property (@(posedge clk) !rst_n |=> (q == '0));

    // R7: disabled port holds its output.
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(q));

endmodule

// File: rtl/twin_view_ram.sv
// Top of the twin-aspect memory: 4096 bits with two synchronous ports,
// each at its own width. The ports share one clock edge. Writes are
// blocked while rst_n is low. Read outputs show post-write contents.
module twin_view_ram
    import twin_view_pkg::*;
#(
    parameter int unsigned TOTAL_BITS = 4096,
    parameter int unsigned A_WIDTH    = 8,
    parameter int unsigned B_WIDTH    = 2,
    parameter int unsigned A_AW       = $clog2(TOTAL_BITS / A_WIDTH),
    parameter int unsigned B_AW       = $clog2(TOTAL_BITS / B_WIDTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               a_en,
    input  logic               a_we,
    input  logic [A_AW-1:0]    a_addr,
    input  logic [A_WIDTH-1:0] a_wdata,
    output logic [A_WIDTH-1:0] a_rdata,
    input  logic               b_en,
    input  logic               b_we,
    input  logic [B_AW-1:0]    b_addr,
    input  logic [B_WIDTH-1:0] b_wdata,
    output logic [B_WIDTH-1:0] b_rdata
);
    localparam int unsigned ROWS = TOTAL_BITS / ROW_BITS;
    localparam int unsigned RAW  = $clog2(ROWS);
    localparam int unsigned SHW  = $clog2(ROW_BITS);

    logic [RAW-1:0]      row_a, row_b;
    logic [SHW-1:0]      sh_a, sh_b;
    logic [ROW_BITS-1:0] mask_a, mask_b, data_a, data_b, next_a, next_b;
    logic                wr_a, wr_b;

    // R10: only the legal widths may be configured.
    initial begin
        a_r10_width_set: assert (legal_width(A_WIDTH) && legal_width(B_WIDTH)
                                 && (TOTAL_BITS % ROW_BITS == 0))
            else $error("illegal port width");
    end

    // Write strobes qualified by enable and reset.
    always_comb begin
        wr_a = rst_n && a_en && a_we;
        wr_b = rst_n && b_en && b_we;
    end

    tv_lane_decode #(.WIDTH(A_WIDTH), .TOTAL(TOTAL_BITS), .ROWW(ROW_BITS)) u_dec_a (
        .addr(a_addr), .wdata(a_wdata), .row(row_a), .shift(sh_a),
        .mask(mask_a), .wrow(data_a));

    tv_lane_decode #(.WIDTH(B_WIDTH), .TOTAL(TOTAL_BITS), .ROWW(ROW_BITS)) u_dec_b (
        .addr(b_addr), .wdata(b_wdata), .row(row_b), .shift(sh_b),
        .mask(mask_b), .wrow(data_b));

    tv_array #(.ROWS(ROWS)) u_array (
        .clk(clk), .rst_n(rst_n),
        .wr_a(wr_a), .row_a(row_a), .mask_a(mask_a), .data_a(data_a),
        .wr_b(wr_b), .row_b(row_b), .mask_b(mask_b), .data_b(data_b),
        .next_a(next_a), .next_b(next_b));

    tv_read_reg #(.WIDTH(A_WIDTH), .ROWW(ROW_BITS)) u_rd_a (
        .clk(clk), .rst_n(rst_n), .en(a_en), .row_val(next_a), .shift(sh_a),
        .q(a_rdata));

    tv_read_reg #(.WIDTH(B_WIDTH), .ROWW(ROW_BITS)) u_rd_b (
        .clk(clk), .rst_n(rst_n), .en(b_en), .row_val(next_b), .shift(sh_b),
        .q(b_rdata));

    // R4: a writing port reads back its own data (A always wins).
    a_r4_write_first: assert property (@(posedge clk) disable iff (!rst_n)
        (a_en && a_we) |=> (a_rdata == $past(a_wdata)));

endmodule

// File: tb/sim_twin_view_ram.sv
module sim_twin_view_ram;
    localparam int unsigned AW = 8, BW = 2;
    localparam int unsigned AAW = 9, BAW = 11;

    logic clk = 1'b0, rst_n = 1'b0;
    logic a_en = 0, a_we = 0, b_en = 0, b_we = 0;
    logic [AAW-1:0] a_addr = '0;
    logic [BAW-1:0] b_addr = '0;
    logic [AW-1:0]  a_wdata = '0, a_rdata;
    logic [BW-1:0]  b_wdata = '0, b_rdata;

    int checks = 0, fails = 0;
    bit done = 0;
    logic [4095:0] model;
    logic [AW-1:0] exp_a = '0;
    logic [BW-1:0] exp_b = '0;

    always #2 clk = ~clk;

    twin_view_ram #(.A_WIDTH(AW), .B_WIDTH(BW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata),
        .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata));

    function automatic logic [AW-1:0] rd_a(input logic [AAW-1:0] k);
        return model[k*AW +: AW];
    endfunction
    function automatic logic [BW-1:0] rd_b(input logic [BAW-1:0] k);
        return model[k*BW +: BW];
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one cycle at negedge, update the model, sample at the next negedge.
    task automatic cyc(input string tag, input logic ae, input logic awe,
                       input logic [AAW-1:0] aad, input logic [AW-1:0] awd,
                       input logic be, input logic bwe,
                       input logic [BAW-1:0] bad, input logic [BW-1:0] bwd,
                       input bit check);
        a_en = ae; a_we = awe; a_addr = aad; a_wdata = awd;
        b_en = be; b_we = bwe; b_addr = bad; b_wdata = bwd;
        if (rst_n) begin
            if (be && bwe) model[bad*BW +: BW] = bwd;
            if (ae && awe) model[aad*AW +: AW] = awd;
            if (ae) exp_a = rd_a(aad);
            if (be) exp_b = rd_b(bad);
        end else begin
            exp_a = '0; exp_b = '0;
        end
        @(posedge clk);
        @(negedge clk);
        if (check) begin
            chk({tag, " port A"}, 16'(a_rdata), 16'(exp_a));
            chk({tag, " port B"}, 16'(b_rdata), 16'(exp_b));
        end
    endtask

    initial begin
        #800000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] keep_a;
        logic [1:0] keep_b;
        void'($urandom(32'd2718));
        model = '0;
        @(negedge clk);
        // R1: reset clears outputs
        cyc("R1 reset", 0, 0, 0, 0, 0, 0, 0, 0, 1);
        rst_n = 1'b1;
        // Fill the array through port A with a known pattern (R2 setup)
        for (int k = 0; k < 512; k++)
            cyc("init", 1, 1, AAW'(k), AW'(k * 37 + 5), 0, 0, 0, 0, 0);
        // R2: byte 3 = A5 seen as bit pairs on port B (words 12..15)
        cyc("R2 write", 1, 1, 9'd3, 8'hA5, 0, 0, 0, 0, 1);
        cyc("R2 low pair", 0, 0, 0, 0, 1, 0, 11'd12, 0, 1);
        chk("R2 literal word12", 16'(b_rdata), 16'h1);
        cyc("R2 high pair", 0, 0, 0, 0, 1, 0, 11'd15, 0, 1);
        chk("R2 literal word15", 16'(b_rdata), 16'h2);
        // R2: bit pairs written on B read as a byte on A
        cyc("R2 b write0", 0, 0, 0, 0, 1, 1, 11'd40, 2'b11, 1);
        cyc("R2 b write1", 0, 0, 0, 0, 1, 1, 11'd41, 2'b00, 1);
        cyc("R2 b write2", 0, 0, 0, 0, 1, 1, 11'd42, 2'b01, 1);
        cyc("R2 b write3", 0, 0, 0, 0, 1, 1, 11'd43, 2'b10, 1);
        cyc("R2 a read", 1, 0, 9'd10, 0, 0, 0, 0, 0, 1);
        chk("R2 literal byte10", 16'(a_rdata), 16'h93);
        // R3: address change without an edge leaves the output alone
        a_addr = 9'd100;
        #1;
        chk("R3 no edge", 16'(a_rdata), 16'h93);
        cyc("R3 after edge", 1, 0, 9'd100, 0, 0, 0, 0, 0, 1);
        // R4: write-first on both ports
        cyc("R4 write-first", 1, 1, 9'd20, 8'h5E, 1, 1, 11'd200, 2'b10, 1);
        chk("R4 literal A", 16'(a_rdata), 16'h5E);
        chk("R4 literal B", 16'(b_rdata), 16'h2);
        // R5: overlap, A wins (byte 5 = bits 40..47, B word 20 = bits 40..41)
        cyc("R5 collide", 1, 1, 9'd5, 8'h3C, 1, 1, 11'd20, 2'b11, 1);
        chk("R5 literal B", 16'(b_rdata), 16'h0);
        chk("R5 literal A", 16'(a_rdata), 16'h3C);
        // R9: simultaneous writes to distinct bits both land
        cyc("R9 both", 1, 1, 9'd6, 8'h81, 1, 1, 11'd100, 2'b01, 1);
        cyc("R9 readback", 1, 0, 9'd25, 0, 1, 0, 11'd24, 0, 1);
        chk("R9 literal B", 16'(b_rdata), 16'h1);
        // R6: A reads byte 7 while B writes bits 56..57
        cyc("R6 cross read", 1, 0, 9'd7, 0, 1, 1, 11'd28, 2'b10, 1);
        chk("R6 literal low pair", 16'(a_rdata[1:0]), 16'h2);
        // R7: disabled port ignores write and holds output
        keep_a = a_rdata;
        cyc("R7 hold", 0, 1, 9'd7, 8'hFF, 0, 1, 11'd28, 2'b01, 1);
        chk("R7 literal held", 16'(a_rdata), 16'(keep_a));
        cyc("R7 not written", 1, 0, 9'd7, 0, 1, 0, 11'd28, 0, 1);
        chk("R7 literal pair", 16'(b_rdata), 16'h2);
        // R8: enabled reads with write enable low change nothing
        cyc("R8 read", 1, 0, 9'd30, 8'hEE, 1, 0, 11'd121, 2'b11, 1);
        cyc("R8 reread", 1, 0, 9'd30, 0, 1, 0, 11'd121, 0, 1);
        // R1: no write while reset is low
        keep_b = rd_b(11'd120);
        rst_n = 1'b0;
        cyc("R1 reset write", 1, 1, 9'd30, 8'h00, 1, 1, 11'd120, ~keep_b, 1);
        rst_n = 1'b1;
        cyc("R1 reset kept", 1, 0, 9'd30, 0, 1, 0, 11'd120, 0, 1);
        chk("R1 literal pair", 16'(b_rdata), 16'(keep_b));
        // R9: random traffic with forced overlaps
        for (int i = 0; i < 4000; i++) begin
            logic [AAW-1:0] ra;
            logic [BAW-1:0] rb;
            ra = AAW'($urandom);
            rb = ($urandom_range(0, 3) == 0) ? BAW'({ra, 2'($urandom)}) : BAW'($urandom);
            cyc("R9 random", $urandom_range(0, 3) != 0, 1'($urandom),
                ra, AW'($urandom), $urandom_range(0, 3) != 0, 1'($urandom),
                rb, BW'($urandom), 1);
        end
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule